// File: doc/BRIEF.md
# Serial audio link enable crossing controller

This block owns the on/off state of a serial audio link. Software writes an enable bit in a fast register clock domain. The block applies that bit at once to the gating of DMA requests, interrupts and data-register reads on the register side. It then carries the bit across to a much slower bit-clock domain, where it enables the link, holds the receive path in reset while the link is off, and produces the frame-sync level.

The crossing uses a toggle request and a toggle acknowledge. Each direction passes through a two-flop synchronizer. Only one transfer is in flight at a time. A value written while a transfer is busy goes into a single pending slot, and any later write overwrites it. When the acknowledge returns, the newest pending value is sent, so values written in between never reach the link.

On the bit-clock side, a 6-bit counter runs while the link is enabled, and frame-sync follows its top bit. While the link is disabled, the counter is held at zero and frame-sync keeps its last level. The transmit path is outside this block and is never reset by it.

Top module: `audlink_enable_xing`

## Requirements
- R1: While `rst_n` is low, and after it is released, `dma_req_out`, `irq_out` and `rd_data_out` are all zero, `link_en` is 0, `rx_clr` is 1, `fsync` is 0, and no transfer is pending.
- R2: `dma_req_out` and `irq_out` equal `dma_req_in` and `irq_in` while the last written enable is 1, and are all zero while it is 0. The change takes effect on the `clk_reg` edge that accepts the write, before `link_en` follows.
- R3: `rd_data_out` equals `rd_data_in` while the last written enable is 1, and is all zero while it is 0.
- R4: A written value reaches `link_en` on the fourth rising `clk_bit` edge after the request toggle is launched. The launch happens one `clk_reg` edge after the write when no transfer is busy. `link_en` changes only when a handshake delivers a value.
- R5: Writes made while a transfer is in flight are merged. Only the last value written is sent after the acknowledge returns, and an intermediate value never appears on `link_en`.
- R6: `rx_clr` is 1 exactly while `link_en` is 0, and the bit counter is held at zero while the link is disabled.
- R7: While enabled, `fsync` is the top bit of a 6-bit bit-clock counter. It first rises 32 `clk_bit` edges after `link_en` rises, then toggles every 32 edges.
- R8: While `link_en` is 0, `fsync` does not change.
- R9: Each time the link is enabled, the counter restarts from zero. If `fsync` was held high, it drops to 0 on the first enabled `clk_bit` edge.
- R10: Asserting `rst_n` while a transfer is pending or in flight discards that transfer. After release, `link_en` stays 0 until a new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_reg | input | 1 | Fast register-side clock |
| clk_bit | input | 1 | Slow serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cfg_wr | input | 1 | Write strobe for the enable bit (clk_reg) |
| cfg_en | input | 1 | Enable value to write |
| dma_req_in | input | N_DMA | Raw DMA requests from the FIFOs |
| dma_req_out | output | N_DMA | Gated DMA requests |
| irq_in | input | N_IRQ | Raw interrupt sources |
| irq_out | output | N_IRQ | Gated interrupts |
| rd_data_in | input | DATA_W | Raw data-register read value |
| rd_data_out | output | DATA_W | Read value, zeroed while disabled |
| link_en | output | 1 | Link enable in the bit-clock domain |
| rx_clr | output | 1 | Receive FIFO, pointer and counter reset (bit-clock domain) |
| fsync | output | 1 | Frame-sync level |

## Verification
The bound checker tests several relations on every edge of their clocks. Register-side gating of DMA requests, interrupts and read data must match the written enable. A pending value must survive while a transfer is busy. `link_en` may change only after a load strobe from the handshake. While the link is off, the counter must be zero and `fsync` must be frozen. While the link is on, `fsync` must track the counter's top bit.

Other behaviours only the bench scenarios can show. These are the end-to-end latency measured at the ports, the 32-edge frame-sync timing after enable and after re-enable, and the fact that a burst of writes never lets an intermediate value reach `link_en`. The bench also shows that a reset in the middle of a transfer leaves no stale value to be delivered.

// File: rtl/audlink_pkg.sv
package audlink_pkg;
  localparam int unsigned FS_CNT_W = 6;
  localparam int unsigned FS_HALF  = 1 << (FS_CNT_W - 1);

  typedef logic [FS_CNT_W-1:0] fs_cnt_t;

  // Next bit-counter value: counts while running, held at zero otherwise.
  function automatic fs_cnt_t fs_cnt_step(input fs_cnt_t c, input logic run);
    return run ? fs_cnt_t'(c + 1'b1) : '0;
  endfunction

  // Frame-sync level carried by a counter value.
  function automatic logic fs_level(input fs_cnt_t c);
    return c[FS_CNT_W-1];
  endfunction
endpackage

// File: rtl/audlink_sync.sv
module audlink_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES < 2) begin : g_single
      logic ff;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= 1'b0;
        else        ff <= d;
      end
      assign q = ff;
    end else begin : g_chain
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '0;
        else        ff <= {ff[STAGES-2:0], d};
      end
      assign q = ff[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/audlink_gate.sv
module audlink_gate #(
  parameter int unsigned W = 1
) (
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  assign q = en ? d : '0;
endmodule

// File: rtl/audlink_reg_side.sv
module audlink_reg_side (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  input  logic ack_sync,
  output logic en_wr,
  output logic req_tgl,
  output logic xfer_val,
  output logic launch,
  output logic busy,
  output logic pend_valid
);
  logic en_q, pend_v, pend_d, req_q, xfer_q;

  assign busy   = req_q ^ ack_sync;
  assign launch = pend_v & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_v <= 1'b0;
      pend_d <= 1'b0;
      req_q  <= 1'b0;
      xfer_q <= 1'b0;
    end else begin
      if (wr_en) en_q <= wr_val;
      if (launch) begin
        req_q  <= ~req_q;
        xfer_q <= pend_d;
      end
      if (wr_en) begin
        pend_v <= 1'b1;
        pend_d <= wr_val;
      end else if (launch) begin
        pend_v <= 1'b0;
      end
    end
  end

  assign en_wr      = en_q;
  assign req_tgl    = req_q;
  assign xfer_val   = xfer_q;
  assign pend_valid = pend_v;
endmodule

// File: rtl/audlink_bit_side.sv
module audlink_bit_side
  import audlink_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_tgl,
  input  logic    xfer_val,
  output logic    link_en,
  output logic    ack_tgl,
  output logic    load,
  output logic    rx_clr,
  output logic    fsync,
  output fs_cnt_t cnt
);
  logic    req_s, req_seen, load_q, en_q, ack_q, fs_q;
  fs_cnt_t cnt_q;
  logic    req_edge;

  audlink_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
  );

  assign req_edge = req_s ^ req_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen <= 1'b0;
      load_q   <= 1'b0;
      en_q     <= 1'b0;
      ack_q    <= 1'b0;
      fs_q     <= 1'b0;
      cnt_q    <= '0;
    end else begin
      req_seen <= req_s;
      load_q   <= req_edge;
      if (load_q) en_q <= xfer_val;
      ack_q    <= ack_q ^ load_q;
      cnt_q    <= fs_cnt_step(cnt_q, en_q);
      if (en_q) fs_q <= fs_level(fs_cnt_step(cnt_q, 1'b1));
    end
  end

  assign link_en = en_q;
  assign ack_tgl = ack_q;
  assign load    = load_q;
  assign rx_clr  = ~en_q;
  assign fsync   = fs_q;
  assign cnt     = cnt_q;
endmodule

// File: rtl/audlink_enable_xing.sv
module audlink_enable_xing
  import audlink_pkg::*;
#(
  parameter int unsigned N_DMA       = 2,
  parameter int unsigned N_IRQ       = 3,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_reg,
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic [N_DMA-1:0]  dma_req_in,
  output logic [N_DMA-1:0]  dma_req_out,
  input  logic [N_IRQ-1:0]  irq_in,
  output logic [N_IRQ-1:0]  irq_out,
  input  logic [DATA_W-1:0] rd_data_in,
  output logic [DATA_W-1:0] rd_data_out,
  output logic              link_en,
  output logic              rx_clr,
  output logic              fsync
);
  // Internal events, named for the checker.
  logic    en_wr, req_tgl, xfer_val, launch, busy, pend_valid;
  logic    ack_tgl, ack_sync, load;
  fs_cnt_t cnt;

  audlink_reg_side u_reg (
    .clk(clk_reg), .rst_n(rst_n), .wr_en(cfg_wr), .wr_val(cfg_en),
    .ack_sync(ack_sync), .en_wr(en_wr), .req_tgl(req_tgl),
    .xfer_val(xfer_val), .launch(launch), .busy(busy),
    .pend_valid(pend_valid)
  );

  audlink_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk_reg), .rst_n(rst_n), .d(ack_tgl), .q(ack_sync)
  );

  audlink_bit_side #(.SYNC_STAGES(SYNC_STAGES)) u_bit (
    .clk(clk_bit), .rst_n(rst_n), .req_tgl(req_tgl), .xfer_val(xfer_val),
    .link_en(link_en), .ack_tgl(ack_tgl), .load(load), .rx_clr(rx_clr),
    .fsync(fsync), .cnt(cnt)
  );

  audlink_gate #(.W(N_DMA))  u_gate_dma (.en(en_wr), .d(dma_req_in), .q(dma_req_out));
  audlink_gate #(.W(N_IRQ))  u_gate_irq (.en(en_wr), .d(irq_in),     .q(irq_out));
  audlink_gate #(.W(DATA_W)) u_gate_rd  (.en(en_wr), .d(rd_data_in), .q(rd_data_out));
endmodule

// File: rtl/audlink_enable_xing_chk.sv
module audlink_enable_xing_chk
  import audlink_pkg::*;
#(
  parameter int unsigned N_DMA  = 2,
  parameter int unsigned N_IRQ  = 3,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_reg,
  input logic              clk_bit,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              en_wr,
  input logic              busy,
  input logic              pend_valid,
  input logic [N_DMA-1:0]  dma_req_out,
  input logic [N_IRQ-1:0]  irq_out,
  input logic [DATA_W-1:0] rd_data_out,
  input logic              link_en,
  input logic              load,
  input logic              fsync,
  input fs_cnt_t           cnt
);
  // R2: requests and interrupts masked while written enable is off
  a_r2_masked: assert property (@(posedge clk_reg) disable iff (!rst_n)
    !en_wr |-> (dma_req_out == '0 && irq_out == '0));

  // R3: reads return zero while written enable is off
  a_r3_read_zero: assert property (@(posedge clk_reg) disable iff (!rst_n)
    !en_wr |-> rd_data_out == '0);

  // R5: a pending value is kept while a transfer is still busy
  a_r5_pending_kept: assert property (@(posedge clk_reg) disable iff (!rst_n)
    (pend_valid && busy) |=> pend_valid);

  // R4: link enable changes only after a handshake load strobe
  a_r4_change_on_load: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (link_en != $past(link_en)) |-> $past(load));

  // R6: counter held at zero while disabled
  a_r6_count_clear: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !link_en |=> cnt == '0);

  // R7: frame-sync follows counter top bit while enabled
  a_r7_fsync_tracks: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $past(link_en) |-> fsync == fs_level(cnt));

  // R8: frame-sync frozen while disabled
  a_r8_fsync_hold: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !link_en |=> $stable(fsync));

  // R9: counter starts from zero at every enable
  a_r9_restart: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $rose(link_en) |-> cnt == '0);

  logic unused_wr;
  assign unused_wr = cfg_wr;
endmodule

bind audlink_enable_xing audlink_enable_xing_chk #(
  .N_DMA(N_DMA), .N_IRQ(N_IRQ), .DATA_W(DATA_W)
) u_chk (
  .clk_reg(clk_reg), .clk_bit(clk_bit), .rst_n(rst_n), .cfg_wr(cfg_wr),
  .en_wr(en_wr), .busy(busy), .pend_valid(pend_valid),
  .dma_req_out(dma_req_out), .irq_out(irq_out), .rd_data_out(rd_data_out),
  .link_en(link_en), .load(load), .fsync(fsync), .cnt(cnt)
);

// File: tb/tb_audlink_enable_xing.sv
module tb_audlink_enable_xing;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_PERIOD = 72;
  localparam int N_DMA  = 2;
  localparam int N_IRQ  = 3;
  localparam int DATA_W = 32;
  localparam int HALF   = 32;

  logic clk_reg = 1'b0, clk_bit = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_en = 1'b0;
  logic [N_DMA-1:0]  dma_req_in = 2'b11;
  logic [N_IRQ-1:0]  irq_in = 3'b101;
  logic [DATA_W-1:0] rd_data_in = 32'hA5C3_5A3C;
  logic [N_DMA-1:0]  dma_req_out;
  logic [N_IRQ-1:0]  irq_out;
  logic [DATA_W-1:0] rd_data_out;
  logic link_en, rx_clr, fsync;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk_reg = ~clk_reg;
  always #(BIT_PERIOD/2) clk_bit = ~clk_bit;

  audlink_enable_xing #(.N_DMA(N_DMA), .N_IRQ(N_IRQ), .DATA_W(DATA_W)) dut (
    .clk_reg(clk_reg), .clk_bit(clk_bit), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .dma_req_in(dma_req_in), .dma_req_out(dma_req_out),
    .irq_in(irq_in), .irq_out(irq_out),
    .rd_data_in(rd_data_in), .rd_data_out(rd_data_out),
    .link_en(link_en), .rx_clr(rx_clr), .fsync(fsync)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_en(input logic v);
    @(negedge clk_reg);
    cfg_wr = 1'b1;
    cfg_en = v;
    @(negedge clk_reg);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_link(input logic v, output int n);
    n = 0;
    while (link_en !== v && n < 40) begin
      @(negedge clk_bit);
      n++;
    end
  endtask

  task automatic wait_fsync(input logic v, output int n);
    n = 0;
    while (fsync !== v && n < 200) begin
      @(negedge clk_bit);
      n++;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_reg);
    check(dma_req_out == '0, "R1", "dma in reset", dma_req_out, 0);
    check(irq_out == '0, "R1", "irq in reset", irq_out, 0);
    check(rd_data_out == '0, "R1", "rd in reset", rd_data_out, 0);
    check(link_en === 1'b0, "R1", "link_en in reset", link_en, 0);
    check(rx_clr === 1'b1, "R1", "rx_clr in reset", rx_clr, 1);
    check(fsync === 1'b0, "R1", "fsync in reset", fsync, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk_bit);
    check(link_en === 1'b0, "R1", "link_en after release", link_en, 0);
  endtask

  task automatic t_gate_disabled();
    @(negedge clk_reg);
    check(dma_req_out == '0 && irq_out == '0, "R2", "masked while off",
          {dma_req_out, irq_out}, 0);
    check(rd_data_out == '0, "R3", "read zero while off", rd_data_out, 0);
  endtask

  task automatic t_enable();
    int n;
    write_en(1'b1);
    check(dma_req_out == dma_req_in && irq_out == irq_in, "R2", "pass after write",
          {dma_req_out, irq_out}, {dma_req_in, irq_in});
    check(rd_data_out == rd_data_in, "R3", "read pass when on", rd_data_out, rd_data_in);
    check(link_en === 1'b0, "R2", "reg side leads link", link_en, 0);
    wait_link(1'b1, n);
    check(n >= 4 && n <= 5, "R4", "enable latency (bit negedges)", n, 4);
    check(rx_clr === 1'b0, "R6", "rx_clr off when enabled", rx_clr, 0);
    wait_fsync(1'b1, n);
    check(n == HALF, "R7", "first fsync rise", n, HALF);
    wait_fsync(1'b0, n);
    check(n == HALF, "R7", "fsync high time", n, HALF);
  endtask

  task automatic t_disable_hold();
    int n;
    int changes;
    logic hold;
    wait_fsync(1'b1, n);
    write_en(1'b0);
    check(dma_req_out == '0 && rd_data_out == '0, "R2", "mask right after write",
          {dma_req_out, rd_data_out}, 0);
    wait_link(1'b0, n);
    check(n >= 4 && n <= 5, "R4", "disable latency", n, 4);
    check(rx_clr === 1'b1, "R6", "rx_clr when disabled", rx_clr, 1);
    hold = fsync;
    check(hold === 1'b1, "R8", "held level at disable", hold, 1);
    changes = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk_bit);
      if (fsync !== hold) changes++;
    end
    check(changes == 0, "R8", "fsync changes while off", changes, 0);
  endtask

  task automatic t_reenable();
    int n;
    write_en(1'b1);
    wait_link(1'b1, n);
    check(fsync === 1'b1, "R8", "held level at re-enable", fsync, 1);
    @(negedge clk_bit);
    check(fsync === 1'b0, "R9", "drop on first enabled edge", fsync, 0);
    wait_fsync(1'b1, n);
    check(n + 1 == HALF, "R9", "rise after restart", n + 1, HALF);
  endtask

  task automatic t_coalesce_on();
    int n;
    int falls;
    logic prev;
    write_en(1'b0);
    wait_link(1'b0, n);
    @(negedge clk_reg); cfg_wr = 1'b1; cfg_en = 1'b1;
    @(negedge clk_reg); cfg_en = 1'b0;
    @(negedge clk_reg); cfg_en = 1'b1;
    @(negedge clk_reg); cfg_wr = 1'b0;
    falls = 0;
    prev  = link_en;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_bit);
      if (prev === 1'b1 && link_en === 1'b0) falls++;
      prev = link_en;
    end
    check(falls == 0, "R5", "intermediate 0 reached link", falls, 0);
    check(link_en === 1'b1, "R5", "last value on link", link_en, 1);
  endtask

  task automatic t_coalesce_off();
    int rises;
    logic prev;
    @(negedge clk_reg); cfg_wr = 1'b1; cfg_en = 1'b0;
    @(negedge clk_reg); cfg_en = 1'b1;
    @(negedge clk_reg); cfg_en = 1'b0;
    @(negedge clk_reg); cfg_wr = 1'b0;
    rises = 0;
    prev  = link_en;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_bit);
      if (prev === 1'b0 && link_en === 1'b1) rises++;
      prev = link_en;
    end
    check(rises == 0, "R5", "intermediate 1 reached link", rises, 0);
    check(link_en === 1'b0 && rx_clr === 1'b1, "R5", "last value off",
          {link_en, rx_clr}, 2'b01);
  endtask

  task automatic t_async_reset();
    write_en(1'b1);
    @(negedge clk_reg);
    rst_n = 1'b0;
    repeat (3) @(negedge clk_reg);
    rst_n = 1'b1;
    repeat (20) @(negedge clk_bit);
    check(link_en === 1'b0, "R10", "no stale delivery", link_en, 0);
    check(dma_req_out == '0, "R10", "written enable cleared", dma_req_out, 0);
    check(fsync === 1'b0 && rx_clr === 1'b1, "R10", "bit side cleared",
          {fsync, rx_clr}, 2'b01);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_gate_disabled();
    t_enable();
    t_disable_hold();
    t_reenable();
    t_coalesce_on();
    t_coalesce_off();
    t_async_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule